// File: doc/BRIEF.md
# Cascadable presettable binary counter

A small synchronous up-counter whose state advances by one on each rising clock edge when enabled, wrapping from all ones back to zero. A registered parallel load lets the state be preset from a data bus, which makes the block usable as a programmable divider. The width defaults to four bits, giving a modulo-16 sequence.

Counting is gated by two active-high enables. The parallel enable only gates the increment. The trickle enable gates the increment and also qualifies the combinational carry output. Because of this split, several stages can be chained into one wide synchronous counter. Each stage's carry drives the next stage's trickle enable, and a single common enable drives every parallel enable.

A parameter picks how the clear input works. In one variant it is an asynchronous clear that overrides everything at once. In the other it is a clear taken on the next rising edge. The order of precedence is fixed: clear, then load, then count, then hold. The carry output is combinational and may glitch, so it must not be used as a clock or as an asynchronous reset.

Top module: `casc_bin_counter`

## Requirements
- R1: When counting from the all-ones state (15 at default width), the next state is 0.
- R2: With ASYNC_CLR=1, a low rst_ni forces state_o to 0 immediately, with no clock edge needed, and keeps it there while rst_ni stays low.
- R3: With ASYNC_CLR=0, a low rst_ni leaves state_o unchanged until the next rising edge, then clears it to 0. This happens even when load_ni is low and both enables are high.
- R4: With rst_ni high and load_ni low, the next rising edge copies data_i into state_o, whatever the values of both enables.
- R5: With rst_ni and load_ni high and both en_par_i and en_trk_i high, each rising edge increments state_o by one.
- R6: With rst_ni and load_ni high and either enable low, state_o holds its value across the edge.
- R7: carry_o is 1 exactly when state_o is all ones and en_trk_i is 1, in the same cycle. It does not depend on load_ni or en_par_i.
- R8: When load_ni is low while both enables are high, the load wins over the count.
- R9: Three stages chained as carry to next trickle enable, with a common parallel enable, count as one 12-bit binary counter. This includes the wrap from 4095 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Active-low clear (asynchronous or synchronous per ASYNC_CLR) |
| load_ni | input | 1 | Active-low parallel load request |
| data_i | input | WIDTH | Preset value |
| en_par_i | input | 1 | Parallel count enable, active high |
| en_trk_i | input | 1 | Trickle count enable, active high; also qualifies carry_o |
| state_o | output | WIDTH | Counter state |
| carry_o | output | 1 | Terminal-count carry, combinational |

## Verification
Load, count, hold and the synchronous clear are each due one rising edge after the inputs are applied. The bench therefore drives at a falling edge and compares at the following falling edge. The asynchronous clear is due within the same cycle, so it is checked 1 ns after rst_ni falls, with no edge in between, while the synchronous variant is checked at that moment to still hold its old value. carry_o is combinational and is compared in the same half-cycle in which state_o or en_trk_i changes. A behavioural model advanced on every rising edge is compared against both variants after every edge. The 12-bit cascade is compared against an ordinary integer counter.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_COUNT = 2'd1,
    MODE_LOAD  = 2'd2,
    MODE_CLEAR = 2'd3
  } cnt_mode_e;
endpackage

// File: rtl/cnt_mode_dec.sv
module cnt_mode_dec
  import cnt_pkg::*;
(
  input  logic      clr_req_i,
  input  logic      load_ni,
  input  logic      en_par_i,
  input  logic      en_trk_i,
  output cnt_mode_e mode_o
);
  // fixed precedence: clear > load > count > hold
  always_comb begin
    if (clr_req_i)              mode_o = MODE_CLEAR;
    else if (!load_ni)          mode_o = MODE_LOAD;
    else if (en_par_i && en_trk_i) mode_o = MODE_COUNT;
    else                        mode_o = MODE_HOLD;
  end
endmodule

// File: rtl/cnt_next_state.sv
module cnt_next_state
  import cnt_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  cnt_mode_e          mode_i,
  input  logic [WIDTH-1:0]   state_i,
  input  logic [WIDTH-1:0]   data_i,
  output logic [WIDTH-1:0]   next_o
);
  always_comb begin
    unique case (mode_i)
      MODE_CLEAR: next_o = '0;
      MODE_LOAD:  next_o = data_i;
      MODE_COUNT: next_o = state_i + WIDTH'(1);
      default:    next_o = state_i;
    endcase
  end
endmodule

// File: rtl/cnt_state_reg.sv
module cnt_state_reg #(
  parameter int unsigned WIDTH     = 4,
  parameter bit          ASYNC_CLR = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] next_i,
  output logic [WIDTH-1:0] q_o
);
  generate
    if (ASYNC_CLR) begin : g_async
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_o <= '0;
        else         q_o <= next_i;
      end

      p_async_clear_r2: assert property (@(posedge clk_i) !rst_ni |-> (q_o == '0))
        else $error("R2: state not cleared during async clear");
    end else begin : g_sync
      // clear arrives through next_i from the mode decoder
      always_ff @(posedge clk_i) begin
        q_o <= next_i;
      end

      p_sync_clear_r3: assert property (@(posedge clk_i) !rst_ni |=> (q_o == '0))
        else $error("R3: state not cleared after sync clear edge");
    end
  endgenerate
endmodule

// File: rtl/cnt_carry_dec.sv
module cnt_carry_dec #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] state_i,
  input  logic             en_trk_i,
  output logic             carry_o
);
  assign carry_o = (&state_i) & en_trk_i;
endmodule

// File: rtl/casc_bin_counter.sv
module casc_bin_counter
  import cnt_pkg::*;
#(
  parameter int unsigned WIDTH     = 4,
  parameter bit          ASYNC_CLR = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             en_par_i,
  input  logic             en_trk_i,
  output logic [WIDTH-1:0] state_o,
  output logic             carry_o
);
  localparam logic [WIDTH-1:0] MaxVal = {WIDTH{1'b1}};

  logic             clr_req;
  cnt_mode_e        mode;
  logic [WIDTH-1:0] next_state;

  assign clr_req = ASYNC_CLR ? 1'b0 : ~rst_ni;

  cnt_mode_dec u_mode (
    .clr_req_i (clr_req),
    .load_ni   (load_ni),
    .en_par_i  (en_par_i),
    .en_trk_i  (en_trk_i),
    .mode_o    (mode)
  );

  cnt_next_state #(.WIDTH(WIDTH)) u_next (
    .mode_i  (mode),
    .state_i (state_o),
    .data_i  (data_i),
    .next_o  (next_state)
  );

  cnt_state_reg #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .next_i (next_state),
    .q_o    (state_o)
  );

  cnt_carry_dec #(.WIDTH(WIDTH)) u_carry (
    .state_i  (state_o),
    .en_trk_i (en_trk_i),
    .carry_o  (carry_o)
  );

  p_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && en_par_i && en_trk_i && state_o == MaxVal) |=> (state_o == '0))
    else $error("R1: no wrap to zero");

  p_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |=> (state_o == $past(data_i)))
    else $error("R4/R8: load value not taken");

  p_count_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && en_par_i && en_trk_i) |=> (state_o == WIDTH'($past(state_o) + 1'b1)))
    else $error("R5: increment missing");

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !(en_par_i && en_trk_i)) |=> $stable(state_o))
    else $error("R6: state moved while disabled");

  p_carry_hi_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |-> (state_o == MaxVal && en_trk_i))
    else $error("R7: spurious carry");

  p_carry_lo_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == MaxVal && en_trk_i) |-> carry_o)
    else $error("R7: missing carry");
endmodule

// File: tb/casc_bin_counter_tb_top.sv
module casc_bin_counter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       load_n;
  logic [3:0] data;
  logic       en_p, en_t;
  logic [3:0] q_a, q_s;
  logic       co_a, co_s;

  logic        c_rst_n, c_load_n, c_en;
  logic [11:0] c_data;
  logic [3:0]  c_q0, c_q1, c_q2;
  logic        c_co0, c_co1, c_co2;

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0] exp_a, exp_s;

  always #2.5 clk = ~clk;

  casc_bin_counter #(.WIDTH(4), .ASYNC_CLR(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(load_n), .data_i(data),
    .en_par_i(en_p), .en_trk_i(en_t), .state_o(q_a), .carry_o(co_a));

  casc_bin_counter #(.WIDTH(4), .ASYNC_CLR(1'b0)) dut_s_i (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(load_n), .data_i(data),
    .en_par_i(en_p), .en_trk_i(en_t), .state_o(q_s), .carry_o(co_s));

  // three-stage cascade
  casc_bin_counter #(.WIDTH(4), .ASYNC_CLR(1'b1)) st0_i (
    .clk_i(clk), .rst_ni(c_rst_n), .load_ni(c_load_n), .data_i(c_data[3:0]),
    .en_par_i(c_en), .en_trk_i(c_en), .state_o(c_q0), .carry_o(c_co0));
  casc_bin_counter #(.WIDTH(4), .ASYNC_CLR(1'b1)) st1_i (
    .clk_i(clk), .rst_ni(c_rst_n), .load_ni(c_load_n), .data_i(c_data[7:4]),
    .en_par_i(c_en), .en_trk_i(c_co0), .state_o(c_q1), .carry_o(c_co1));
  casc_bin_counter #(.WIDTH(4), .ASYNC_CLR(1'b1)) st2_i (
    .clk_i(clk), .rst_ni(c_rst_n), .load_ni(c_load_n), .data_i(c_data[11:8]),
    .en_par_i(c_en), .en_trk_i(c_co1), .state_o(c_q2), .carry_o(c_co2));

  // behavioural reference, from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)       exp_a <= 4'd0;
    else if (!load_n) exp_a <= data;
    else if (en_p && en_t) exp_a <= exp_a + 4'd1;
  end
  always @(posedge clk) begin
    if (!rst_n)       exp_s <= 4'd0;
    else if (!load_n) exp_s <= data;
    else if (en_p && en_t) exp_s <= exp_s + 4'd1;
  end

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // one edge, then compare both variants with the model
  task automatic step(input string req);
    @(posedge clk);
    @(negedge clk);
    chk({req, " async"}, 12'(q_a), 12'(exp_a));
    chk({req, " sync"},  12'(q_s), 12'(exp_s));
    chk({req, " carry_a"}, 12'(co_a), 12'((&exp_a) & en_t));
    chk({req, " carry_s"}, 12'(co_s), 12'((&exp_s) & en_t));
  endtask

  task automatic t_reset;
    load_n = 1'b0; data = 4'd9; en_p = 1'b0; en_t = 1'b0;
    step("R4");
    load_n = 1'b1;
    rst_n = 1'b0; load_n = 1'b0; data = 4'd6; en_p = 1'b1; en_t = 1'b1;
    #1;
    chk("R2 immediate clear", 12'(q_a), 12'd0);
    chk("R3 held before edge", 12'(q_s), 12'd9);
    @(negedge clk);
    @(posedge clk); @(negedge clk);
    chk("R3 clear beats load", 12'(q_s), 12'd0);
    chk("R2 held in clear", 12'(q_a), 12'd0);
    rst_n = 1'b1; load_n = 1'b1; en_p = 1'b0; en_t = 1'b0;
    step("R6 after clear");
  endtask

  task automatic t_wrap;
    load_n = 1'b0; data = 4'd14; en_p = 1'b1; en_t = 1'b1;
    step("R4 load 14");
    load_n = 1'b1;
    step("R5 14->15");
    chk("R7 carry at 15", 12'(co_a), 12'd1);
    step("R1 wrap");
    chk("R1 wrap to 0", 12'(q_a), 12'd0);
    chk("R7 no carry at 0", 12'(co_s), 12'd0);
    for (int i = 0; i < 5; i++) step("R5 run");
    chk("R5 count 5", 12'(q_s), 12'd5);
  endtask

  task automatic t_load_priority;
    load_n = 1'b0; data = 4'd3; en_p = 1'b1; en_t = 1'b1;
    step("R8 load over count");
    chk("R8 load value", 12'(q_a), 12'd3);
    en_p = 1'b0; en_t = 1'b0; data = 4'd11;
    step("R4 load with enables low");
    chk("R4 load value", 12'(q_s), 12'd11);
    load_n = 1'b1;
  endtask

  task automatic t_hold_carry;
    load_n = 1'b0; data = 4'd15; en_p = 1'b0; en_t = 1'b1;
    step("R4 load 15");
    load_n = 1'b1;
    step("R6 par low");
    chk("R6 held at 15", 12'(q_a), 12'd15);
    chk("R7 carry with par low", 12'(co_a), 12'd1);
    en_p = 1'b1; en_t = 1'b0; #1;
    chk("R7 carry off with trk low", 12'(co_s), 12'd0);
    step("R6 trk low");
    load_n = 1'b0; data = 4'd2; en_t = 1'b1; #1;
    chk("R7 carry ignores load", 12'(co_a), 12'd1);
    step("R4 reload");
    load_n = 1'b1; en_p = 1'b0; en_t = 1'b0;
  endtask

  task automatic t_cascade;
    logic [11:0] ref_v;
    c_load_n = 1'b0; c_data = 12'hFFA; c_en = 1'b0;
    @(posedge clk); @(negedge clk);
    ref_v = 12'hFFA;
    chk("R9 cascade load", {c_q2, c_q1, c_q0}, ref_v);
    c_load_n = 1'b1; c_en = 1'b1;
    for (int i = 0; i < 300; i++) begin
      @(posedge clk); @(negedge clk);
      ref_v = ref_v + 12'd1;
      chk("R9 cascade count", {c_q2, c_q1, c_q0}, ref_v);
    end
    c_en = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R9 cascade hold", {c_q2, c_q1, c_q0}, ref_v);
  endtask

  initial begin
    rst_n = 1'b1; load_n = 1'b1; data = '0; en_p = 1'b0; en_t = 1'b0;
    c_rst_n = 1'b1; c_load_n = 1'b1; c_data = '0; c_en = 1'b0;
    #1;
    rst_n = 1'b0; c_rst_n = 1'b0;
    @(negedge clk); @(posedge clk); @(negedge clk);
    chk("R2 reset state", 12'(q_a), 12'd0);
    chk("R3 reset state", 12'(q_s), 12'd0);
    chk("R9 reset state", {c_q2, c_q1, c_q0}, 12'd0);
    rst_n = 1'b1; c_rst_n = 1'b1;
    step("R6 idle");
    t_reset();
    t_wrap();
    t_load_priority();
    t_hold_carry();
    t_cascade();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule